// File: doc/BRIEF.md
# SPI Status Poll Sequencer

This block takes the repeated status check of a serial flash part off the host. After one start request it frames a short SPI exchange on its own: chip select goes low, a command byte goes out, one dummy byte brings back a response, and chip select goes high again. It ANDs the response with a host mask and compares the result with a host value. It repeats the exchange until the two are equal or until an attempt limit runs out. The common case is to poll a read-status command until the write-in-progress bit clears.

A second mode waits a fixed number of microseconds instead of polling. The microsecond timebase comes from a clocks-per-microsecond parameter. Either mode ends with a one-cycle done pulse. The pass/timeout flag, the last response byte and the number of attempts used stay valid until the next start. The byte shifter sits outside the block and is reached through a request/acknowledge handshake that moves one byte at a time.

Top module: `poll_seq`

## Requirements
- R1: After reset, cs_n is 1, and xfer_req, busy, done and matched are 0. last_resp and iter_count are 0.
- R2: Each poll attempt drives cs_n low and transfers two bytes with cs_n held low. The first byte is cmd_byte and the second is the dummy byte 8'h00. The response is the xfer_rx value accepted with the second transfer. cs_n then returns to 1. xfer_req is only ever high while cs_n is 0.
- R3: When (response & rsp_mask) == rsp_want, the run stops with matched = 1. Mask bits that are 0 have no influence on the comparison.
- R4: A run makes at most iter_limit attempts, and an iter_limit of 0 allows exactly one attempt. If no attempt matches, done arrives with matched = 0 and iter_count equal to that attempt cap.
- R5: done is high for exactly one cycle. At that point last_resp holds the final response and iter_count the attempts used. Both values, and matched, hold until the next accepted start.
- R6: Between two attempts of one run, cs_n stays high for at least GAP_CYCLES clock cycles.
- R7: With mode_delay = 1, done rises delay_us × CLK_PER_US cycles after the edge that accepts start, so a delay_us of 0 gives done on that edge. No SPI transfer takes place, and matched and iter_count read 0.
- R8: A start that arrives while busy is 1 has no effect. The running command, its parameters and its results are unchanged.
- R9: busy goes high on the edge that accepts start and stays high through the done cycle. It is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled while idle |
| mode_delay | input | 1 | 1 = fixed microsecond wait, 0 = poll loop |
| cmd_byte | input | 8 | Command byte sent at the start of each attempt |
| rsp_mask | input | 8 | Mask ANDed with the response |
| rsp_want | input | 8 | Value the masked response must equal |
| iter_limit | input | 16 | Attempt cap (0 means one attempt) |
| delay_us | input | 16 | Wait length in microseconds |
| cs_n | output | 1 | Chip select, active low |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Shifter finished the byte |
| xfer_rx | input | 8 | Byte received during the transfer |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| matched | output | 1 | 1 = mask compare met, 0 = limit reached |
| last_resp | output | 8 | Last response byte |
| iter_count | output | 16 | Attempts used |

## Verification
The bench builds the block with CLK_PER_US = 5 and GAP_CYCLES = 3. With these values, waits of several microseconds finish in a few dozen cycles and can be measured exactly to the cycle. A short chip-select gap keeps runs of up to eight attempts brief. A small gap also means that an error of one cycle in the gap counter would show up against the minimum. The shifter model acknowledges each byte one cycle after the request. This lets the bench check every command and dummy byte, count the frames, and measure the high time of chip select between frames.

// File: rtl/poll_seq_pkg.sv
package poll_seq_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;

  localparam logic [BYTE_W-1:0] DUMMY_BYTE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD,
    ST_RSP,
    ST_EVAL,
    ST_GAP,
    ST_DLY,
    ST_DONE
  } seq_state_t;

  // masked equality between a response and the wanted value
  function automatic logic masked_hit(input logic [BYTE_W-1:0] rsp,
                                      input logic [BYTE_W-1:0] mask,
                                      input logic [BYTE_W-1:0] want);
    return (rsp & mask) == want;
  endfunction

  // number of attempts a limit field allows
  function automatic logic [CNT_W-1:0] attempt_cap(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? CNT_W'(1) : lim;
  endfunction

endpackage

// File: rtl/poll_us_tick.sv
module poll_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre;

  assign tick = run && (pre == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre <= '0;
    end else if (tick) begin
      pre <= '0;
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end
endmodule

// File: rtl/poll_down_ctr.sv
module poll_down_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         is_zero
);
  assign is_zero = (value == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end else if (dec && !is_zero) begin
      value <= value - W'(1);
    end
  end
endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import poll_seq_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int GAP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_delay,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [BYTE_W-1:0] rsp_mask,
  input  logic [BYTE_W-1:0] rsp_want,
  input  logic [CNT_W-1:0]  iter_limit,
  input  logic [CNT_W-1:0]  delay_us,
  output logic              cs_n,
  output logic              xfer_req,
  output logic [BYTE_W-1:0] xfer_tx,
  input  logic              xfer_ack,
  input  logic [BYTE_W-1:0] xfer_rx,
  output logic              busy,
  output logic              done,
  output logic              matched,
  output logic [BYTE_W-1:0] last_resp,
  output logic [CNT_W-1:0]  iter_count
);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES - 1);

  seq_state_t state, state_nx;

  logic [BYTE_W-1:0] cmd_q, mask_q, want_q;
  logic [CNT_W-1:0]  lim_eff;
  logic              mode_q;

  // named internal events
  logic accept, byte_done, resp_hit, cap_reached, gap_over;
  logic us_tick, delay_end, gap_load;
  logic [GAP_W-1:0] gap_val;
  logic             gap_zero;
  logic [CNT_W-1:0] dly_val;
  logic             dly_zero;

  assign accept      = (state == ST_IDLE) && start;
  assign byte_done   = xfer_req && xfer_ack;
  assign resp_hit    = (state == ST_EVAL) && masked_hit(last_resp, mask_q, want_q);
  assign cap_reached = (state == ST_EVAL) && (iter_count >= lim_eff);
  assign gap_load    = (state == ST_EVAL);
  assign gap_over    = (state == ST_GAP) && gap_zero;
  assign delay_end   = (state == ST_DLY) && us_tick && (dly_val == CNT_W'(1));

  poll_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == ST_DLY),
    .tick (us_tick)
  );

  poll_down_ctr #(.W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .load_val(GAP_LOAD),
    .dec     (state == ST_GAP),
    .value   (gap_val),
    .is_zero (gap_zero)
  );

  poll_down_ctr #(.W(CNT_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val(delay_us),
    .dec     (us_tick),
    .value   (dly_val),
    .is_zero (dly_zero)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (!mode_delay)         state_nx = ST_SEL;
        else if (delay_us == '0) state_nx = ST_DONE;
        else                     state_nx = ST_DLY;
      end
      ST_SEL:  state_nx = ST_CMD;
      ST_CMD:  if (xfer_ack) state_nx = ST_RSP;
      ST_RSP:  if (xfer_ack) state_nx = ST_EVAL;
      ST_EVAL: state_nx = (resp_hit || cap_reached) ? ST_DONE : ST_GAP;
      ST_GAP:  if (gap_over) state_nx = ST_SEL;
      ST_DLY:  if (delay_end) state_nx = ST_DONE;
      ST_DONE: state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cmd_q      <= '0;
      mask_q     <= '0;
      want_q     <= '0;
      lim_eff    <= CNT_W'(1);
      mode_q     <= 1'b0;
      matched    <= 1'b0;
      last_resp  <= '0;
      iter_count <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        cmd_q      <= cmd_byte;
        mask_q     <= rsp_mask;
        want_q     <= rsp_want;
        lim_eff    <= attempt_cap(iter_limit);
        mode_q     <= mode_delay;
        matched    <= 1'b0;
        last_resp  <= '0;
        iter_count <= '0;
      end
      if (state == ST_RSP && xfer_ack) begin
        last_resp  <= xfer_rx;
        iter_count <= iter_count + CNT_W'(1);
      end
      if (resp_hit) matched <= 1'b1;
    end
  end

  assign cs_n     = !((state == ST_SEL) || (state == ST_CMD) || (state == ST_RSP));
  assign xfer_req = (state == ST_CMD) || (state == ST_RSP);
  assign xfer_tx  = (state == ST_CMD) ? cmd_q : DUMMY_BYTE;
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/poll_seq_chk.sv
module poll_seq_chk
  import poll_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cs_n,
  input logic              xfer_req,
  input logic              busy,
  input logic              done,
  input logic              matched,
  input logic              mode_q,
  input logic [BYTE_W-1:0] last_resp,
  input logic [BYTE_W-1:0] mask_q,
  input logic [BYTE_W-1:0] want_q,
  input logic [BYTE_W-1:0] cmd_q,
  input logic [CNT_W-1:0]  lim_eff,
  input logic [CNT_W-1:0]  iter_count
);
  logic [7:0] hi_cnt;
  logic       seen_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (cs_n) hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
      else      hi_cnt <= '0;
      if (!busy)      seen_frame <= 1'b0;
      else if (!cs_n) seen_frame <= 1'b1;
    end
  end

  // R2
  req_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !cs_n);

  // R3
  match_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && matched) |-> ((last_resp & mask_q) == want_q));

  // R4
  timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !matched && !mode_q) |-> (iter_count == lim_eff));

  // R4
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> (iter_count <= lim_eff));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_frame) |-> (hi_cnt >= 8'(GAP_CYCLES)));

  // R7
  delay_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |-> (cs_n && iter_count == '0 && !matched));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cmd_q));

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

bind poll_seq poll_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cs_n      (cs_n),
  .xfer_req  (xfer_req),
  .busy      (busy),
  .done      (done),
  .matched   (matched),
  .mode_q    (mode_q),
  .last_resp (last_resp),
  .mask_q    (mask_q),
  .want_q    (want_q),
  .cmd_q     (cmd_q),
  .lim_eff   (lim_eff),
  .iter_count(iter_count)
);

// File: tb/poll_seq_bench.sv
module poll_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 5;
  localparam int GAP = 3;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode_delay = 1'b0;
  logic [7:0]  cmd_byte = 8'h00, rsp_mask = 8'h00, rsp_want = 8'h00;
  logic [15:0] iter_limit = 16'd0, delay_us = 16'd0;
  logic        cs_n, xfer_req, busy, done, matched;
  logic [7:0]  xfer_tx, last_resp;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'h00;
  logic [15:0] iter_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_seq #(.CLK_PER_US(CPU), .GAP_CYCLES(GAP)) u_poll_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_delay(mode_delay),
    .cmd_byte(cmd_byte), .rsp_mask(rsp_mask), .rsp_want(rsp_want),
    .iter_limit(iter_limit), .delay_us(delay_us), .cs_n(cs_n),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack),
    .xfer_rx(xfer_rx), .busy(busy), .done(done), .matched(matched),
    .last_resp(last_resp), .iter_count(iter_count)
  );

  int total = 0;
  int fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // shifter model and frame monitor
  logic [7:0]  exp_cmd = 8'h00, bad_rsp = 8'h00, good_rsp = 8'h00;
  logic [15:0] good_from = 16'hFFFF;
  int frames = 0, byte_idx = 0, tx_err = 0, hi_run = 0, min_gap = 999;
  logic cs_q = 1'b1;

  always @(posedge clk) begin
    cs_q <= cs_n;
    if (cs_q && !cs_n) begin
      frames <= frames + 1;
      if (frames > 0 && hi_run < min_gap) min_gap <= hi_run;
    end
    if (cs_n) begin
      hi_run   <= hi_run + 1;
      byte_idx <= 0;
    end else begin
      hi_run <= 0;
    end
    if (xfer_req && !xfer_ack) begin
      xfer_ack <= 1'b1;
      if (byte_idx == 0) begin
        if (xfer_tx !== exp_cmd) tx_err <= tx_err + 1;
      end else begin
        if (xfer_tx !== 8'h00) tx_err <= tx_err + 1;
        xfer_rx <= (frames >= int'(good_from)) ? good_rsp : bad_rsp;
      end
      if (!cs_n) byte_idx <= byte_idx + 1;
    end else begin
      xfer_ack <= 1'b0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  typedef struct packed {
    logic [7:0]  cmd;
    logic [7:0]  mask;
    logic [7:0]  want;
    logic [15:0] lim;
    logic [7:0]  bad;
    logic [7:0]  good;
    logic [15:0] from;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h05, 8'h01, 8'h00, 16'd5, 8'h03, 8'h02, 16'd3},
    '{8'h05, 8'h01, 8'h00, 16'd0, 8'h01, 8'h00, 16'hFFFF},
    '{8'h70, 8'h80, 8'h80, 16'd4, 8'h00, 8'h80, 16'hFFFF},
    '{8'h05, 8'h01, 8'h00, 16'd8, 8'hFE, 8'hFE, 16'd1},
    '{8'h35, 8'h03, 8'h02, 16'd3, 8'h01, 8'h0A, 16'd3},
    '{8'h05, 8'h00, 8'h00, 16'd6, 8'h5A, 8'h5A, 16'hFFFF},
    '{8'h9F, 8'hFF, 8'h00, 16'd1, 8'h01, 8'h00, 16'hFFFF}
  };

  task automatic launch(input logic md, input vec_t v, input logic [15:0] d);
    @(negedge clk);
    mode_delay = md; cmd_byte = v.cmd; rsp_mask = v.mask; rsp_want = v.want;
    iter_limit = v.lim; delay_us = d;
    exp_cmd = v.cmd; bad_rsp = v.bad; good_rsp = v.good; good_from = v.from;
    frames = 0; tx_err = 0; min_gap = 999;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    int cap, n_exp;
    logic m_exp;
    logic [7:0] r_exp, r;
    cap = (v.lim == 0) ? 1 : int'(v.lim);
    m_exp = 1'b0; n_exp = 0; r_exp = 8'h00;
    for (int n = 1; n <= cap && !m_exp; n++) begin
      r = (n >= int'(v.from)) ? v.good : v.bad;
      n_exp = n; r_exp = r;
      if ((r & v.mask) == v.want) m_exp = 1'b1;
    end
    launch(1'b0, v, 16'd0);
    check({"R9 busy after accept ", tag}, busy, 1);
    wait_done();
    check({"R3/R4 matched ", tag}, matched, m_exp);
    check({"R5 iter_count ", tag}, iter_count, n_exp);
    check({"R5 last_resp ", tag}, last_resp, r_exp);
    check({"R2 frame count ", tag}, frames, n_exp);
    check({"R2 tx bytes ", tag}, tx_err, 0);
    if (n_exp > 1) check({"R6 cs gap ", tag}, (min_gap >= GAP), 1);
    @(negedge clk);
    check({"R5 done one cycle ", tag}, done, 0);
    check({"R9 idle after done ", tag}, busy, 0);
    repeat (3) @(negedge clk);
    check({"R5 hold ", tag}, {matched, last_resp, iter_count}, {m_exp, r_exp, 16'(n_exp)});
  endtask

  task automatic run_delay(input logic [15:0] d);
    int n;
    vec_t z;
    z = '{8'h05, 8'hFF, 8'hFF, 16'd3, 8'h00, 8'h00, 16'hFFFF};
    launch(1'b1, z, d);
    n = 0;
    while (!done) begin @(negedge clk); n++; end
    check($sformatf("R7 delay %0d cycles", d), n, int'(d) * CPU);
    check($sformatf("R7 delay %0d no frames", d), frames, 0);
    check($sformatf("R7 delay %0d results", d), {matched, iter_count}, 17'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset cs_n", cs_n, 1);
    check("R1 reset outputs", {xfer_req, busy, done, matched, last_resp, iter_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {busy, cs_n}, 2'b01);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));

    run_delay(16'd0);
    run_delay(16'd1);
    run_delay(16'd7);

    // R8: start while busy is ignored
    begin
      vec_t lv;
      lv = '{8'h05, 8'h01, 8'h00, 16'd6, 8'h01, 8'h00, 16'hFFFF};
      launch(1'b0, lv, 16'd0);
      repeat (5) @(negedge clk);
      mode_delay = 1'b1; cmd_byte = 8'hAB; iter_limit = 16'd1; delay_us = 16'd2;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check("R8 iterations unchanged", iter_count, 6);
      check("R8 matched unchanged", matched, 0);
      check("R8 command unchanged", tx_err, 0);
      check("R8 frames", frames, 6);
      @(negedge clk);
      check("R8 idle after run", busy, 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule